// File: doc/BRIEF.md
# Transaction clock-domain bridge

This block moves one bus transaction at a time from a source clock domain into an unrelated destination clock domain, then carries a completion back. The source side gives a one-cycle request pulse together with a packed payload: a write flag, a read flag, an address and write data. The destination side sees a one-cycle write enable with the address and write data, or a one-cycle read enable with the address. The destination's 32-bit read data is sampled and returned to the source, where a one-cycle acknowledge marks completion with the return word valid in that cycle.

Crossing uses a toggle handshake. The source holds the payload in a register and flips a request toggle. The destination sees the flip through a two-flop synchronizer and only then copies the held payload. An acknowledge toggle crosses back the same way. No multi-bit value is sampled across the boundary while it can change. Each domain has its own active-low asynchronous reset.

Top module: `xferBridge`

## Requirements
- R1: After reset, srcAck, dstWrEn and dstRdEn are all low.
- R2: The payload is packed from the top down. Bit ADDR_W+33 is the write flag, bit ADDR_W+32 is the read flag, bits ADDR_W+31..32 are the address and bits 31..0 are the write data. It is 56 bits wide at the default ADDR_W of 22.
- R3: A request with the write flag set produces exactly one dstWrEn pulse, one destination cycle long. During that pulse, dstAddr and dstWdata equal the address and data fields of the request.
- R4: A request with only the read flag set produces exactly one dstRdEn pulse, one destination cycle long, with dstAddr equal to the request address. No dstWrEn is produced.
- R5: For a read, the value on dstRdata one destination cycle after the dstRdEn cycle appears on srcRdata in the srcAck cycle. A later change of dstRdata does not alter it.
- R6: Every request produces exactly one srcAck pulse, one source cycle long. This holds for reads and for writes.
- R7: A request with neither flag set drives no dstWrEn and no dstRdEn, and is still acknowledged once.
- R8: The payload is taken only in the request cycle. Changing srcPayload after that cycle has no effect on the transaction.
- R9: Only one transaction is outstanding at a time. A new request is issued only after the acknowledge of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source domain asynchronous reset, active low |
| srcReq | input | 1 | One-cycle request pulse |
| srcPayload | input | ADDR_W+34 | Packed transaction, valid with srcReq |
| srcAck | output | 1 | One-cycle completion pulse |
| srcRdata | output | 32 | Return word, valid with srcAck |
| dstClk | input | 1 | Destination domain clock |
| dstRstN | input | 1 | Destination domain asynchronous reset, active low |
| dstAddr | output | ADDR_W | Transaction address |
| dstWrEn | output | 1 | One-cycle write enable |
| dstWdata | output | 32 | Write data, valid with dstWrEn |
| dstRdEn | output | 1 | One-cycle read enable |
| dstRdata | input | 32 | Read data, sampled one cycle after dstRdEn |

## Verification
The assertions assume that the source never raises srcReq while a transaction is in flight. They also assume that the destination is idle whenever a new request toggle arrives. The bench keeps within this by waiting for srcAck before each new request, then letting several destination cycles pass. The destination model drives the read word in the dstRdEn cycle and holds it for one more cycle. It then scrambles the word, so a sample taken at the wrong time would show in the check.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int DATA_W = 32;
  localparam int FLAG_W = 2;

  typedef struct packed {
    logic srcCapture;
    logic dstCapture;
    logic dstRetCapture;
    logic srcRetCapture;
  } xfer_strobe_t;
endpackage

// File: rtl/syncTwoFlop.sv
module syncTwoFlop #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xferCtrl.sv
module xferCtrl
  import xfer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         srcClk,
  input  logic         srcRstN,
  input  logic         srcReq,
  output logic         srcAck,
  input  logic         dstClk,
  input  logic         dstRstN,
  input  logic         holdWr,
  input  logic         holdRd,
  output logic         dstWrEn,
  output logic         dstRdEn,
  output xfer_strobe_t strobes
);
  typedef enum logic [1:0] {DST_IDLE, DST_ISSUE, DST_CAPT} dst_state_t;

  // source domain
  logic reqTog, ackSyncQ, ackSeen, ackEdge, srcAckQ, busy;
  // destination domain
  logic ackTog, reqSyncQ, reqSeen, reqEdge, wrEnQ, rdEnQ;
  dst_state_t dstState;

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) begin
      reqTog  <= 1'b0;
      ackSeen <= 1'b0;
      srcAckQ <= 1'b0;
      busy    <= 1'b0;
    end else begin
      if (srcReq) reqTog <= ~reqTog;
      ackSeen <= ackSyncQ;
      srcAckQ <= ackEdge;
      if (srcReq)       busy <= 1'b1;
      else if (ackEdge) busy <= 1'b0;
    end
  end

  syncTwoFlop #(.STAGES(SYNC_STAGES)) uAckSync (
    .clk(srcClk), .rstN(srcRstN), .d(ackTog), .q(ackSyncQ)
  );

  assign ackEdge = ackSyncQ ^ ackSeen;
  assign srcAck  = srcAckQ;

  syncTwoFlop #(.STAGES(SYNC_STAGES)) uReqSync (
    .clk(dstClk), .rstN(dstRstN), .d(reqTog), .q(reqSyncQ)
  );

  assign reqEdge = reqSyncQ ^ reqSeen;

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      dstState <= DST_IDLE;
      reqSeen  <= 1'b0;
      ackTog   <= 1'b0;
      wrEnQ    <= 1'b0;
      rdEnQ    <= 1'b0;
    end else begin
      unique case (dstState)
        DST_IDLE: begin
          if (reqEdge) begin
            reqSeen  <= reqSyncQ;
            wrEnQ    <= holdWr;
            rdEnQ    <= holdRd;
            dstState <= DST_ISSUE;
          end
        end
        DST_ISSUE: begin
          wrEnQ    <= 1'b0;
          rdEnQ    <= 1'b0;
          dstState <= DST_CAPT;
        end
        DST_CAPT: begin
          ackTog   <= ~ackTog;
          dstState <= DST_IDLE;
        end
        default: dstState <= DST_IDLE;
      endcase
    end
  end

  assign dstWrEn = wrEnQ;
  assign dstRdEn = rdEnQ;

  always_comb begin
    strobes.srcCapture    = srcReq;
    strobes.srcRetCapture = ackEdge;
    strobes.dstCapture    = (dstState == DST_IDLE) && reqEdge;
    strobes.dstRetCapture = (dstState == DST_CAPT);
  end

  // R3: the write enable lasts a single destination cycle
  assert_wr_single_R3: assert property (@(posedge dstClk) disable iff (!dstRstN)
    dstWrEn |=> !dstWrEn);
  // R4: the read enable lasts a single destination cycle
  assert_rd_single_R4: assert property (@(posedge dstClk) disable iff (!dstRstN)
    dstRdEn |=> !dstRdEn);
  // R6: the acknowledge lasts a single source cycle
  assert_ack_single_R6: assert property (@(posedge srcClk) disable iff (!srcRstN)
    srcAck |=> !srcAck);
  // R9: no request while one is outstanding
  assert_one_outstanding_R9: assert property (@(posedge srcClk) disable iff (!srcRstN)
    srcReq |-> !busy);
  // R9: a request toggle only reaches an idle destination
  assert_dst_idle_on_req_R9: assert property (@(posedge dstClk) disable iff (!dstRstN)
    reqEdge |-> (dstState == DST_IDLE));
endmodule

// File: rtl/xferPath.sv
module xferPath
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 22,
  localparam int PAY_W = ADDR_W + FLAG_W + DATA_W
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic [PAY_W-1:0]  srcPayload,
  output logic [DATA_W-1:0] srcRdata,
  input  logic              dstClk,
  input  logic              dstRstN,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [DATA_W-1:0] dstWdata,
  input  logic [DATA_W-1:0] dstRdata,
  output logic              holdWr,
  output logic              holdRd,
  input  xfer_strobe_t      strobes
);
  localparam int WR_BIT  = PAY_W - 1;
  localparam int RD_BIT  = PAY_W - 2;
  localparam int ADDR_LO = DATA_W;
  localparam int ADDR_HI = DATA_W + ADDR_W - 1;

  logic [PAY_W-1:0]  holdReg;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, retReg, srcRdataQ;

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) begin
      holdReg   <= '0;
      srcRdataQ <= '0;
    end else begin
      if (strobes.srcCapture)    holdReg   <= srcPayload;
      if (strobes.srcRetCapture) srcRdataQ <= retReg;
    end
  end

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      retReg <= '0;
    end else begin
      if (strobes.dstCapture) begin
        addrQ  <= holdReg[ADDR_HI:ADDR_LO];
        wdataQ <= holdReg[DATA_W-1:0];
      end
      if (strobes.dstRetCapture) retReg <= dstRdata;
    end
  end

  assign holdWr   = holdReg[WR_BIT];
  assign holdRd   = holdReg[RD_BIT];
  assign dstAddr  = addrQ;
  assign dstWdata = wdataQ;
  assign srcRdata = srcRdataQ;

  // R8: the held payload does not move while the destination copies it
  assert_hold_stable_R8: assert property (@(posedge srcClk) disable iff (!srcRstN)
    !strobes.srcCapture |=> $stable(holdReg));
  // R5: the return word reaching the source only changes on an acknowledge
  assert_ret_stable_R5: assert property (@(posedge srcClk) disable iff (!srcRstN)
    !strobes.srcRetCapture |=> $stable(srcRdata));
endmodule

// File: rtl/xferBridge.sv
module xferBridge
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic                     srcClk,
  input  logic                     srcRstN,
  input  logic                     srcReq,
  input  logic [ADDR_W+33:0]       srcPayload,
  output logic                     srcAck,
  output logic [31:0]              srcRdata,
  input  logic                     dstClk,
  input  logic                     dstRstN,
  output logic [ADDR_W-1:0]        dstAddr,
  output logic                     dstWrEn,
  output logic [31:0]              dstWdata,
  output logic                     dstRdEn,
  input  logic [31:0]              dstRdata
);
  xfer_strobe_t strobes;
  logic holdWr, holdRd;

  xferCtrl uCtrl (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcReq(srcReq), .srcAck(srcAck),
    .dstClk(dstClk), .dstRstN(dstRstN), .holdWr(holdWr), .holdRd(holdRd),
    .dstWrEn(dstWrEn), .dstRdEn(dstRdEn), .strobes(strobes)
  );

  xferPath #(.ADDR_W(ADDR_W)) uPath (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcPayload(srcPayload),
    .srcRdata(srcRdata), .dstClk(dstClk), .dstRstN(dstRstN),
    .dstAddr(dstAddr), .dstWdata(dstWdata), .dstRdata(dstRdata),
    .holdWr(holdWr), .holdRd(holdRd), .strobes(strobes)
  );

  // R3: address and write data hold still on the cycle after a write enable
  assert_wr_fields_stable_R3: assert property (@(posedge dstClk) disable iff (!dstRstN)
    dstWrEn |=> ($stable(dstAddr) && $stable(dstWdata)));
  // R4: address holds still while the read word is being returned
  assert_rd_addr_stable_R4: assert property (@(posedge dstClk) disable iff (!dstRstN)
    dstRdEn |=> $stable(dstAddr));
endmodule

// File: tb/sim_xferBridge.sv
`timescale 1ns/1ps
module sim_xferBridge;
  localparam int  ADDR_W  = 22;
  localparam int  PAY_W   = ADDR_W + 34;
  localparam time SRC_PER = 10ns;
  localparam time DST_PER = 17ns;

  logic              srcClk = 0, dstClk = 0;
  logic              srcRstN = 0, dstRstN = 0;
  logic              srcReq = 0;
  logic [PAY_W-1:0]  srcPayload = '0;
  logic              srcAck;
  logic [31:0]       srcRdata;
  logic [ADDR_W-1:0] dstAddr;
  logic              dstWrEn, dstRdEn;
  logic [31:0]       dstWdata;
  logic [31:0]       dstRdata = '0;

  int checks = 0, errors = 0;
  int wrCount = 0, rdCount = 0, ackCount = 0, rdAgo = 0;
  logic [ADDR_W-1:0] lastWrAddr = '0, lastRdAddr = '0;
  logic [31:0]       lastWrData = '0;

  always #(SRC_PER/2) srcClk = ~srcClk;
  always #(DST_PER/2) dstClk = ~dstClk;

  xferBridge #(.ADDR_W(ADDR_W)) u0 (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcReq(srcReq), .srcPayload(srcPayload),
    .srcAck(srcAck), .srcRdata(srcRdata), .dstClk(dstClk), .dstRstN(dstRstN),
    .dstAddr(dstAddr), .dstWrEn(dstWrEn), .dstWdata(dstWdata), .dstRdEn(dstRdEn),
    .dstRdata(dstRdata)
  );

  function automatic logic [31:0] rdVal(input logic [ADDR_W-1:0] a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5AA5A5;
  endfunction

  // destination model: word valid in the read-enable cycle and the next, then scrambled
  always @(negedge dstClk) begin
    if (dstWrEn) begin
      wrCount++;
      lastWrAddr = dstAddr;
      lastWrData = dstWdata;
    end
    if (dstRdEn) begin
      rdCount++;
      lastRdAddr = dstAddr;
      dstRdata = rdVal(dstAddr);
      rdAgo = 1;
    end else if (rdAgo == 1) begin
      rdAgo = 2;
    end else if (rdAgo == 2) begin
      dstRdata = ~dstRdata;
      rdAgo = 0;
    end
  end

  always @(negedge srcClk) if (srcAck) ackCount++;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runTxn(input logic w, input logic r, input logic [ADDR_W-1:0] a,
                        input logic [31:0] d);
    int wr0 = wrCount, rd0 = rdCount, ack0 = ackCount, waitCyc = 0;
    logic [31:0] got;
    @(negedge srcClk);
    srcPayload = {w, r, a, d};          // R2 field order
    srcReq = 1;
    @(negedge srcClk);
    srcReq = 0;
    srcPayload = ~{w, r, a, d};         // R8: must be ignored
    while (!srcAck && waitCyc < 300) begin
      @(negedge srcClk);
      waitCyc++;
    end
    check("R6", "ack seen", 64'(srcAck), 64'd1);
    got = srcRdata;
    @(negedge srcClk);
    check("R6", "ack one cycle", 64'(srcAck), 64'd0);
    repeat (4) @(negedge dstClk);
    check("R6", "ack count", 64'(ackCount - ack0), 64'd1);
    if (w) begin
      check("R3", "write strobes", 64'(wrCount - wr0), 64'd1);
      check("R8", "write addr", 64'(lastWrAddr), 64'(a));
      check("R8", "write data", 64'(lastWrData), 64'(d));
    end else begin
      check("R7", "no write strobe", 64'(wrCount - wr0), 64'd0);
    end
    if (r) begin
      check("R4", "read strobes", 64'(rdCount - rd0), 64'd1);
      check("R4", "read addr", 64'(lastRdAddr), 64'(a));
      check("R5", "read return", 64'(got), 64'(rdVal(a)));
    end else begin
      check("R7", "no read strobe", 64'(rdCount - rd0), 64'd0);
    end
  endtask

  function automatic logic [ADDR_W-1:0] sweepAddr(input int i);
    if (i == 0) return '0;
    if (i == ADDR_W + 1) return '1;
    return ADDR_W'(1) << (i - 1);
  endfunction

  initial begin
    repeat (150000) @(posedge srcClk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge dstClk);
    srcRstN = 1;
    dstRstN = 1;
    repeat (3) @(negedge srcClk);
    check("R1", "srcAck after reset", 64'(srcAck), 64'd0);
    check("R1", "dstWrEn after reset", 64'(dstWrEn), 64'd0);
    check("R1", "dstRdEn after reset", 64'(dstRdEn), 64'd0);

    // R3 / R8: writes over a walking-one address sweep with all-zero and all-one ends
    for (int i = 0; i <= ADDR_W + 1; i++)
      runTxn(1'b1, 1'b0, sweepAddr(i), 32'(i) * 32'h1F3D5B79 + 32'h0BADF00D);
    // R4 / R5: reads over the same sweep
    for (int i = 0; i <= ADDR_W + 1; i++)
      runTxn(1'b0, 1'b1, sweepAddr(i), 32'hFFFFFFFF);
    // R7: neither flag set
    for (int i = 0; i < 4; i++)
      runTxn(1'b0, 1'b0, sweepAddr(i + 3), 32'(i) * 32'h01010101);
    // R9: back-to-back alternating writes and reads, each after the previous ack
    for (int i = 0; i < 16; i++)
      runTxn(i[0], ~i[0], ADDR_W'(i * 97 + 5), 32'(i) ^ 32'hA5A5A5A5);
    // R2: extreme data words on a write
    runTxn(1'b1, 1'b0, '1, 32'h00000000);
    runTxn(1'b1, 1'b0, '0, 32'hFFFFFFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule